// File: doc/BRIEF.md
# Single-Cycle Processor Control Unit

This block is the purely combinational steering logic of a processor that completes one instruction per clock. It receives the fields that fetch has already split out: the 4-bit operation code, the 4-bit function code, the two register fields and the 32-bit constant. It also receives the sequential next-PC value, both register-file read values, the data-memory read value, the ALU result and a branch-taken flag computed elsewhere. From these it produces every select and enable that the datapath needs in the same cycle.

Its outputs cover four areas. The first is the register-file addresses: two read ports, plus a write port E that takes ALU results and a write port M that takes memory results. The second is the two ALU operands, the ALU function and the condition-flag load enable. The third is the data-memory address, write data and the read and write strobes. The last is the program counter for the next cycle. Stack operations reuse the ALU by feeding it a fixed step of plus or minus four. A pop uses both write ports in the same cycle, updating the stack pointer and a general register together.

Top module: `seq_ctl_unit`

Operation codes relied on: 0 no-op, 1 stop, 2 register copy, 3 load-immediate, 4 store, 5 load, 6 arithmetic/logic, 7 jump, 8 call, 9 return, 10 push, 11 pop; 12 to 15 are undefined. Register ID 4 is the stack pointer and ID 8 means "no register". ALU function 0 is add.

## Requirements
- R1: Read address A is the first register field for copy, store, arithmetic and push. It is 4 for pop and return, and 8 for every other code.
- R2: Read address B is the second register field for arithmetic, store and load. It is 4 for push, pop, call and return, and 8 otherwise.
- R3: Write address E is the second register field for copy, load-immediate and arithmetic. It is 4 for push, pop, call and return, and 8 otherwise.
- R4: Write address M is the first register field for load and pop, and 8 otherwise. A pop therefore names two destinations at once.
- R5: ALU operand A is read value A for copy and arithmetic, and the constant for load-immediate, store and load. It is -4 (0xFFFFFFFC) for call and push, +4 for return and pop, and 0 otherwise.
- R6: ALU operand B is read value B for store, load, arithmetic, push, pop, call and return, and 0 for all other codes.
- R7: The ALU function equals the function code for arithmetic and is 0 (add) otherwise. The flag-load enable is high only for arithmetic.
- R8: The memory address is the ALU result for store, push, call and load. It is read value A (the old stack pointer) for pop and return, and 0 otherwise.
- R9: The memory read strobe is high exactly for load, pop and return. The write strobe is high exactly for store, push and call.
- R10: Memory write data is the next-PC value for call, read value A for store and push, and 0 otherwise.
- R11: The new PC is the constant for call and for a jump with the branch flag high. It is the memory read value for return, and the next-PC value otherwise.
- R12: For no-op, stop and codes 12 to 15, all four register addresses are 8, both strobes are low, flags are not loaded and the new PC is the next-PC value.
- R13: The branch flag has no effect on any output for codes other than jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation code of the current instruction |
| fn_code | input | 4 | Function code of the current instruction |
| fld_a | input | 4 | First register field |
| fld_b | input | 4 | Second register field |
| konst | input | 32 | Constant word from the instruction |
| seq_pc | input | 32 | Address of the following instruction |
| rd_val_a | input | 32 | Register file read value, port A |
| rd_val_b | input | 32 | Register file read value, port B |
| mem_rdata | input | 32 | Data memory read value |
| alu_res | input | 32 | ALU result |
| br_taken | input | 1 | Branch condition met |
| src_a | output | 4 | Read address, port A |
| src_b | output | 4 | Read address, port B |
| dst_e | output | 4 | Write address for ALU result |
| dst_m | output | 4 | Write address for memory result |
| alu_x | output | 32 | ALU operand A |
| alu_y | output | 32 | ALU operand B |
| alu_fn | output | 4 | ALU function |
| flag_ld | output | 1 | Load condition flags |
| mem_addr | output | 32 | Data memory address |
| mem_wdata | output | 32 | Data memory write value |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| pc_new | output | 32 | Program counter for the next cycle |

## Verification
Every one of the 16 operation codes is applied while the register fields, constant, read values, memory value, ALU result and next-PC value each hold a distinct pattern. Any wrong mux leg therefore shows up as a recognisably wrong word. The first and second register fields are kept different, so swapped register fields are caught, and the stack step values separate push and call from pop and return. Jump runs with the branch flag both high and low, while arithmetic and call run with the flag opposite to what a leaking path would need; this tells the taken path apart from a flag that bleeds into other codes. All four function codes pass through arithmetic to show the function field reaches the ALU only there.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

   typedef enum logic [3:0] {
      OP_NOP   = 4'h0,
      OP_STOP  = 4'h1,
      OP_MOVRR = 4'h2,
      OP_MOVIR = 4'h3,
      OP_STORE = 4'h4,
      OP_LOAD  = 4'h5,
      OP_ARITH = 4'h6,
      OP_JUMP  = 4'h7,
      OP_CALL  = 4'h8,
      OP_RET   = 4'h9,
      OP_PUSH  = 4'hA,
      OP_POP   = 4'hB
   } op_e;

   typedef struct packed {
      logic movrr;
      logic movir;
      logic store;
      logic load;
      logic arith;
      logic jump;
      logic call;
      logic ret;
      logic push;
      logic pop;
   } insn_cls_t;

endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
   import ctl_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] op_code,
   output insn_cls_t         cls
);
   localparam int NCODES = 1 << CODE_W;

   logic [NCODES-1:0] hit;

   for (genvar k = 0; k < NCODES; k++) begin : g_hit
      assign hit[k] = (op_code == CODE_W'(k));
   end

   assign cls.movrr = hit[OP_MOVRR];
   assign cls.movir = hit[OP_MOVIR];
   assign cls.store = hit[OP_STORE];
   assign cls.load  = hit[OP_LOAD];
   assign cls.arith = hit[OP_ARITH];
   assign cls.jump  = hit[OP_JUMP];
   assign cls.call  = hit[OP_CALL];
   assign cls.ret   = hit[OP_RET];
   assign cls.push  = hit[OP_PUSH];
   assign cls.pop   = hit[OP_POP];
endmodule

// File: rtl/ctl_regsel.sv
module ctl_regsel
   import ctl_pkg::*;
#(
   parameter int RID_W = 4,
   parameter int SP_ID = 4
) (
   input  insn_cls_t        cls,
   input  logic [RID_W-1:0] fld_a,
   input  logic [RID_W-1:0] fld_b,
   output logic [RID_W-1:0] src_a,
   output logic [RID_W-1:0] src_b,
   output logic [RID_W-1:0] dst_e,
   output logic [RID_W-1:0] dst_m
);
   localparam logic [RID_W-1:0] RID_NONE = RID_W'(1 << (RID_W - 1));
   localparam logic [RID_W-1:0] RID_SP   = RID_W'(SP_ID);

   logic stack_op;
   assign stack_op = cls.push | cls.pop | cls.call | cls.ret;

   always_comb begin
      src_a = RID_NONE;
      if (cls.movrr | cls.store | cls.arith | cls.push)
         src_a = fld_a;
      else if (cls.pop | cls.ret)
         src_a = RID_SP;

      src_b = RID_NONE;
      if (cls.arith | cls.store | cls.load)
         src_b = fld_b;
      else if (stack_op)
         src_b = RID_SP;

      dst_e = RID_NONE;
      if (cls.movrr | cls.movir | cls.arith)
         dst_e = fld_b;
      else if (stack_op)
         dst_e = RID_SP;

      dst_m = RID_NONE;
      if (cls.load | cls.pop)
         dst_m = fld_a;
   end
endmodule

// File: rtl/ctl_exesel.sv
module ctl_exesel
   import ctl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CODE_W = 4,
   parameter int STEP   = 4
) (
   input  insn_cls_t         cls,
   input  logic [CODE_W-1:0] fn_code,
   input  logic [DATA_W-1:0] konst,
   input  logic [DATA_W-1:0] rd_val_a,
   input  logic [DATA_W-1:0] rd_val_b,
   output logic [DATA_W-1:0] alu_x,
   output logic [DATA_W-1:0] alu_y,
   output logic [CODE_W-1:0] alu_fn,
   output logic              flag_ld
);
   localparam logic [DATA_W-1:0] STEP_UP   = DATA_W'(STEP);
   localparam logic [DATA_W-1:0] STEP_DOWN = ~STEP_UP + DATA_W'(1);
   localparam logic [CODE_W-1:0] FN_ADD    = '0;

   logic uses_b;
   assign uses_b = cls.arith | cls.store | cls.load |
                   cls.push | cls.pop | cls.call | cls.ret;

   always_comb begin
      alu_x = '0;
      if (cls.movrr | cls.arith)
         alu_x = rd_val_a;
      else if (cls.movir | cls.store | cls.load)
         alu_x = konst;
      else if (cls.call | cls.push)
         alu_x = STEP_DOWN;
      else if (cls.ret | cls.pop)
         alu_x = STEP_UP;
   end

   assign alu_y   = uses_b ? rd_val_b : '0;
   assign alu_fn  = cls.arith ? fn_code : FN_ADD;
   assign flag_ld = cls.arith;
endmodule

// File: rtl/ctl_memsel.sv
module ctl_memsel
   import ctl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  insn_cls_t         cls,
   input  logic              br_taken,
   input  logic [DATA_W-1:0] konst,
   input  logic [DATA_W-1:0] seq_pc,
   input  logic [DATA_W-1:0] rd_val_a,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] alu_res,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] pc_new
);
   logic addr_from_alu, addr_from_sp, go_const;

   assign addr_from_alu = cls.store | cls.push | cls.call | cls.load;
   assign addr_from_sp  = cls.pop | cls.ret;
   assign go_const      = cls.call | (cls.jump & br_taken);

   assign mem_rd = cls.load | cls.pop | cls.ret;
   assign mem_wr = cls.store | cls.push | cls.call;

   always_comb begin
      mem_addr = '0;
      if (addr_from_alu)
         mem_addr = alu_res;
      else if (addr_from_sp)
         mem_addr = rd_val_a;

      mem_wdata = '0;
      if (cls.call)
         mem_wdata = seq_pc;
      else if (cls.store | cls.push)
         mem_wdata = rd_val_a;

      pc_new = seq_pc;
      if (go_const)
         pc_new = konst;
      else if (cls.ret)
         pc_new = mem_rdata;
   end
endmodule

// File: rtl/seq_ctl_unit.sv
module seq_ctl_unit
   import ctl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CODE_W = 4,
   parameter int RID_W  = 4,
   parameter int SP_ID  = 4,
   parameter int STEP   = 4
) (
   input  logic [CODE_W-1:0] op_code,
   input  logic [CODE_W-1:0] fn_code,
   input  logic [RID_W-1:0]  fld_a,
   input  logic [RID_W-1:0]  fld_b,
   input  logic [DATA_W-1:0] konst,
   input  logic [DATA_W-1:0] seq_pc,
   input  logic [DATA_W-1:0] rd_val_a,
   input  logic [DATA_W-1:0] rd_val_b,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              br_taken,
   output logic [RID_W-1:0]  src_a,
   output logic [RID_W-1:0]  src_b,
   output logic [RID_W-1:0]  dst_e,
   output logic [RID_W-1:0]  dst_m,
   output logic [DATA_W-1:0] alu_x,
   output logic [DATA_W-1:0] alu_y,
   output logic [CODE_W-1:0] alu_fn,
   output logic              flag_ld,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] pc_new
);
   if (CODE_W < 4) begin : g_bad_code
      $error("seq_ctl_unit: CODE_W must be at least 4");
   end
   if (RID_W < 4) begin : g_bad_rid
      $error("seq_ctl_unit: RID_W must be at least 4");
   end
   if (SP_ID >= (1 << (RID_W - 1))) begin : g_bad_sp
      $error("seq_ctl_unit: SP_ID collides with the no-register ID");
   end
   if (STEP <= 0 || DATA_W < 8) begin : g_bad_data
      $error("seq_ctl_unit: STEP must be positive and DATA_W at least 8");
   end

   insn_cls_t cls;

   ctl_classify #(.CODE_W(CODE_W)) u_cls (
      .op_code (op_code),
      .cls     (cls)
   );

   ctl_regsel #(.RID_W(RID_W), .SP_ID(SP_ID)) u_reg (
      .cls   (cls),
      .fld_a (fld_a),
      .fld_b (fld_b),
      .src_a (src_a),
      .src_b (src_b),
      .dst_e (dst_e),
      .dst_m (dst_m)
   );

   ctl_exesel #(.DATA_W(DATA_W), .CODE_W(CODE_W), .STEP(STEP)) u_exe (
      .cls      (cls),
      .fn_code  (fn_code),
      .konst    (konst),
      .rd_val_a (rd_val_a),
      .rd_val_b (rd_val_b),
      .alu_x    (alu_x),
      .alu_y    (alu_y),
      .alu_fn   (alu_fn),
      .flag_ld  (flag_ld)
   );

   ctl_memsel #(.DATA_W(DATA_W)) u_mem (
      .cls       (cls),
      .br_taken  (br_taken),
      .konst     (konst),
      .seq_pc    (seq_pc),
      .rd_val_a  (rd_val_a),
      .mem_rdata (mem_rdata),
      .alu_res   (alu_res),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .pc_new    (pc_new)
   );
endmodule

// File: rtl/seq_ctl_chk.sv
module seq_ctl_chk #(
   parameter int DATA_W = 32,
   parameter int CODE_W = 4,
   parameter int RID_W  = 4,
   parameter int SP_ID  = 4,
   parameter int STEP   = 4
) (
   input logic [CODE_W-1:0] op_code,
   input logic [RID_W-1:0]  fld_a,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] seq_pc,
   input logic [RID_W-1:0]  src_a,
   input logic [RID_W-1:0]  src_b,
   input logic [RID_W-1:0]  dst_e,
   input logic [RID_W-1:0]  dst_m,
   input logic [DATA_W-1:0] alu_x,
   input logic              flag_ld,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [DATA_W-1:0] pc_new
);
   localparam logic [RID_W-1:0]  NONE = RID_W'(1 << (RID_W - 1));
   localparam logic [DATA_W-1:0] DOWN = ~DATA_W'(STEP) + DATA_W'(1);

   logic quiet, pushish, popish;
   assign quiet   = (op_code < CODE_W'(2)) || (op_code > CODE_W'(11));
   assign pushish = (op_code == CODE_W'(8)) || (op_code == CODE_W'(10));
   assign popish  = (op_code == CODE_W'(9)) || (op_code == CODE_W'(11));

   always_comb begin
      p_strobe_excl_r9: assert (!(mem_rd && mem_wr))
         else $error("read and write strobes both high");
      p_flags_arith_r7: assert (!flag_ld || op_code == CODE_W'(6))
         else $error("flags loaded by a non-arithmetic code");
      p_dstm_owner_r4: assert (dst_m == NONE || (op_code == CODE_W'(5) || op_code == CODE_W'(11)))
         else $error("port M written by an unexpected code");
      p_pop_two_dst_r4: assert (op_code != CODE_W'(11) || (dst_m == fld_a && dst_e == RID_W'(SP_ID)))
         else $error("pop does not name both destinations");
      p_quiet_r12: assert (!quiet || (src_a == NONE && src_b == NONE && dst_e == NONE &&
                                      dst_m == NONE && !mem_rd && !mem_wr && pc_new == seq_pc))
         else $error("inactive code produced an effect");
      p_ret_pc_r11: assert (op_code != CODE_W'(9) || pc_new == mem_rdata)
         else $error("return did not take memory value");
      p_step_down_r5: assert (!pushish || alu_x == DOWN)
         else $error("push/call step wrong");
      p_stack_read_r1: assert (!popish || src_a == RID_W'(SP_ID))
         else $error("pop/return read port A not stack pointer");
   end
endmodule

bind seq_ctl_unit seq_ctl_chk #(
   .DATA_W(DATA_W), .CODE_W(CODE_W), .RID_W(RID_W), .SP_ID(SP_ID), .STEP(STEP)
) u_chk (
   .op_code   (op_code),
   .fld_a     (fld_a),
   .mem_rdata (mem_rdata),
   .seq_pc    (seq_pc),
   .src_a     (src_a),
   .src_b     (src_b),
   .dst_e     (dst_e),
   .dst_m     (dst_m),
   .alu_x     (alu_x),
   .flag_ld   (flag_ld),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .pc_new    (pc_new)
);

// File: tb/sim_seq_ctl_unit.sv
module sim_seq_ctl_unit;
   localparam logic [3:0]  RA = 4'd1, RB = 4'd6, SP = 4'd4, NO = 4'd8;
   localparam logic [31:0] K  = 32'h1234_5678, NPC = 32'h0000_0100;
   localparam logic [31:0] VA = 32'hA0A0_A0A0, VB = 32'hB0B0_B0B0;
   localparam logic [31:0] MV = 32'hDEAD_BEEF, AR = 32'h5555_0000;
   localparam logic [31:0] UP = 32'd4, DN = 32'hFFFF_FFFC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [3:0]  op_code, fn_code, fld_a, fld_b;
   logic [31:0] konst, seq_pc, rd_val_a, rd_val_b, mem_rdata, alu_res;
   logic        br_taken;
   logic [3:0]  src_a, src_b, dst_e, dst_m, alu_fn;
   logic [31:0] alu_x, alu_y, mem_addr, mem_wdata, pc_new;
   logic        flag_ld, mem_rd, mem_wr;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   seq_ctl_unit u0 (
      .op_code(op_code), .fn_code(fn_code), .fld_a(fld_a), .fld_b(fld_b),
      .konst(konst), .seq_pc(seq_pc), .rd_val_a(rd_val_a), .rd_val_b(rd_val_b),
      .mem_rdata(mem_rdata), .alu_res(alu_res), .br_taken(br_taken),
      .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m),
      .alu_x(alu_x), .alu_y(alu_y), .alu_fn(alu_fn), .flag_ld(flag_ld),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .pc_new(pc_new)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s op=%0h: actual %h expected %h", tag, what, op_code, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [3:0] fn, input logic br);
      @(posedge clk);
      op_code = op; fn_code = fn; br_taken = br;
      @(negedge clk);
   endtask

   task automatic expect_all(input logic [3:0] sa, sb, de, dm,
                             input logic [31:0] ax, ay, input logic [3:0] fn,
                             input logic sf, input logic [31:0] ma, wd,
                             input logic rd, wr, input logic [31:0] pc);
      check("R1",  "src_a",     32'(src_a), 32'(sa));
      check("R2",  "src_b",     32'(src_b), 32'(sb));
      check("R3",  "dst_e",     32'(dst_e), 32'(de));
      check("R4",  "dst_m",     32'(dst_m), 32'(dm));
      check("R5",  "alu_x",     alu_x, ax);
      check("R6",  "alu_y",     alu_y, ay);
      check("R7",  "alu_fn",    32'(alu_fn), 32'(fn));
      check("R7",  "flag_ld",   32'(flag_ld), 32'(sf));
      check("R8",  "mem_addr",  mem_addr, ma);
      check("R10", "mem_wdata", mem_wdata, wd);
      check("R9",  "mem_rd",    32'(mem_rd), 32'(rd));
      check("R9",  "mem_wr",    32'(mem_wr), 32'(wr));
      check("R11", "pc_new",    pc_new, pc);
   endtask

   // R12: idle state with all-zero code
   task automatic t_reset_state();
      apply(4'h0, 4'h0, 1'b0);
      expect_all(NO, NO, NO, NO, 0, 0, 4'h0, 0, 0, 0, 0, 0, NPC);
   endtask

   // R1 R3 R5 R6: register copy and load-immediate
   task automatic t_moves();
      apply(4'h2, 4'h0, 1'b0);
      expect_all(RA, NO, RB, NO, VA, 0, 4'h0, 0, 0, 0, 0, 0, NPC);
      apply(4'h3, 4'h0, 1'b0);
      expect_all(NO, NO, RB, NO, K, 0, 4'h0, 0, 0, 0, 0, 0, NPC);
   endtask

   // R8 R9 R10: store and load
   task automatic t_memory();
      apply(4'h4, 4'h0, 1'b0);
      expect_all(RA, RB, NO, NO, K, VB, 4'h0, 0, AR, VA, 0, 1, NPC);
      apply(4'h5, 4'h0, 1'b0);
      expect_all(NO, RB, NO, RA, K, VB, 4'h0, 0, AR, 0, 1, 0, NPC);
   endtask

   // R7 R13: every arithmetic function, flag high but ignored
   task automatic t_arith();
      for (int f = 0; f < 4; f++) begin
         apply(4'h6, 4'(f), 1'b1);
         expect_all(RA, RB, RB, NO, VA, VB, 4'(f), 1, 0, 0, 0, 0, NPC);
      end
   endtask

   // R11: jump taken and not taken
   task automatic t_jumps();
      apply(4'h7, 4'h3, 1'b1);
      expect_all(NO, NO, NO, NO, 0, 0, 4'h0, 0, 0, 0, 0, 0, K);
      apply(4'h7, 4'h3, 1'b0);
      expect_all(NO, NO, NO, NO, 0, 0, 4'h0, 0, 0, 0, 0, 0, NPC);
   endtask

   // R4 R5 R8 R10 R11 R13: stack traffic
   task automatic t_stack();
      apply(4'h8, 4'h0, 1'b0);
      expect_all(NO, SP, SP, NO, DN, VB, 4'h0, 0, AR, NPC, 0, 1, K);
      apply(4'h9, 4'h0, 1'b0);
      expect_all(SP, SP, SP, NO, UP, VB, 4'h0, 0, VA, 0, 1, 0, MV);
      apply(4'hA, 4'h0, 1'b0);
      expect_all(RA, SP, SP, NO, DN, VB, 4'h0, 0, AR, VA, 0, 1, NPC);
      apply(4'hB, 4'h0, 1'b1);
      expect_all(SP, SP, SP, RA, UP, VB, 4'h0, 0, VA, 0, 1, 0, NPC);
   endtask

   // R12: stop and undefined codes stay inert
   task automatic t_inert();
      apply(4'h1, 4'h2, 1'b1);
      expect_all(NO, NO, NO, NO, 0, 0, 4'h0, 0, 0, 0, 0, 0, NPC);
      for (int c = 12; c < 16; c++) begin
         apply(4'(c), 4'h1, 1'b1);
         expect_all(NO, NO, NO, NO, 0, 0, 4'h0, 0, 0, 0, 0, 0, NPC);
      end
   endtask

   initial begin
      op_code = 4'h0; fn_code = 4'h0; fld_a = RA; fld_b = RB;
      konst = K; seq_pc = NPC; rd_val_a = VA; rd_val_b = VB;
      mem_rdata = MV; alu_res = AR; br_taken = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_moves();
      t_memory();
      t_arith();
      t_jumps();
      t_stack();
      t_inert();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule